// File: doc/BRIEF.md
# Microprogram Sequencer with Flag-Conditioned Branching

This block is the control engine of a small microcoded processor. It keeps a microprogram counter, reads one microinstruction per clock from an internal control store, and forwards the control-signal field of that word to the datapath as a registered output. Every microinstruction carries three fields: a control field, a branch-control field and a branch target. The branch-control field pairs a 3-bit condition with a 2-bit source select. Together they decide where the counter goes next.

The next microaddress comes from one of four places. It can be the counter plus one, the start address that an opcode lookup table returns for the current macro-opcode, an address supplied from outside, or the word's own branch target. The condition is evaluated against the two condition-code flags, negative (N) and zero (Z). When the condition fails, the counter steps by one no matter which source is selected. A word whose control field is all zero performs only a test and branch, so the datapath sees no activity in that step.

The control store and the opcode table are built from fixed formulas inside the RTL. This gives the microprogram a known fetch sequence and a repeating set of test routines that reach every source and every condition.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `upc` becomes 0 and `ctrl_out` becomes 0 after that edge.
- R2: A word with condition code 0 (no branch) moves `upc` to `upc+1` (8-bit) whatever its source select holds.
- R3: When the condition holds and the source select is 2'b10, the next `upc` equals `ext_addr` as sampled at that edge.
- R4: The condition codes are 1 always, 2 when N=1, 3 when N=0, 4 when Z=1 and 5 when Z=0. When the condition holds, source select 2'b00 gives `upc+1` and 2'b11 gives the branch-target field.
- R5: When the condition code is 1 to 5 but the condition is false, the next `upc` is `upc+1`, even if the source select names the table, the external address or the target.
- R6: `ctrl_out` after a rising edge equals the control field of the word at the `upc` value held before that edge. For an address a ≥ 3 with k = a mod 8 and k ≠ 1, that field is {a[7:0], 8'hA0 | k}.
- R7: When the condition holds and the source select is 2'b01, the next `upc` is the lookup table's start address, `opcode` × 8.
- R8: Words 0, 1 and 2 form the fetch sequence. Their control fields are 16'h8001, 16'h8002 and 16'h8004. Words 0 and 1 have condition 0. Word 2 has condition 1 and source select 2'b01.
- R9: For a ≥ 3 the routine is chosen by k = a mod 8. k0: condition 0. k1: control field 0, condition 2, select 11, target a+5. k2: condition 3, select 10. k3: condition 4, select 11, target 0. k4: condition 5, select 01. k5: condition 1, select 00. k6: condition 0, select 11, target 8'h55. k7: condition 1, select 11, target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 5 | Macro-opcode presented to the lookup table |
| ext_addr | input | 8 | Externally supplied microaddress |
| flag_n | input | 1 | Negative condition-code flag |
| flag_z | input | 1 | Zero condition-code flag |
| ctrl_out | output | 16 | Registered control signals to the datapath |
| upc | output | 8 | Current microprogram counter |

## Verification
The two functions that meet in one cycle are the condition gate and the source multiplexer. In a single step, a word may select the lookup table, the external address or its branch target while its flag test fails. The bench provokes this by drawing fresh N, Z, opcode and external address values every clock, so each routine runs under both outcomes of its test. A behavioural model judges every step: it predicts whether the counter falls back to plus one or takes the named source. A synchronous reset is also applied in the middle of the run to collide with whatever branch is active at that moment.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W   = 8;
    localparam int OPC_W  = 5;
    localparam int CTRL_W = 16;
    localparam int DEPTH  = 1 << UA_W;
    localparam int OPS    = 1 << OPC_W;
    localparam int START_SHIFT = 3;

    typedef enum logic [2:0] {
        C_NONE = 3'd0,
        C_ALW  = 3'd1,
        C_NEG  = 3'd2,
        C_NNEG = 3'd3,
        C_ZER  = 3'd4,
        C_NZER = 3'd5,
        C_RSV6 = 3'd6,
        C_RSV7 = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        S_INC = 2'b00,
        S_TBL = 2'b01,
        S_EXT = 2'b10,
        S_TGT = 2'b11
    } src_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        cond_e             cond;
        src_e              src;
        logic [UA_W-1:0]   tgt;
    } uword_t;

    function automatic logic cond_hold(cond_e c, logic n, logic z);
        case (c)
            C_ALW:   return 1'b1;
            C_NEG:   return n;
            C_NNEG:  return !n;
            C_ZER:   return z;
            C_NZER:  return !z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [UA_W-1:0] op_start(logic [OPC_W-1:0] op);
        return UA_W'({op, {START_SHIFT{1'b0}}});
    endfunction

    function automatic uword_t word_at(logic [UA_W-1:0] a);
        uword_t w;
        logic [2:0] k;
        k = a[2:0];
        w.ctrl = {a, 8'hA0 | {5'd0, k}};
        w.cond = C_NONE;
        w.src  = S_INC;
        w.tgt  = '0;
        if (a < UA_W'(3)) begin
            w.ctrl = CTRL_W'(16'h8000 | (16'h1 << a));
            if (a == UA_W'(2)) begin
                w.cond = C_ALW;
                w.src  = S_TBL;
            end
        end else begin
            case (k)
                3'd1: begin
                    w.ctrl = '0;
                    w.cond = C_NEG;
                    w.src  = S_TGT;
                    w.tgt  = UA_W'(a + UA_W'(5));
                end
                3'd2: begin w.cond = C_NNEG; w.src = S_EXT; end
                3'd3: begin w.cond = C_ZER;  w.src = S_TGT; end
                3'd4: begin w.cond = C_NZER; w.src = S_TBL; end
                3'd5: begin w.cond = C_ALW;  w.src = S_INC; end
                3'd6: begin w.cond = C_NONE; w.src = S_TGT; w.tgt = UA_W'(8'h55); end
                3'd7: begin w.cond = C_ALW;  w.src = S_TGT; end
                default: ;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = word_at(UA_W'(i));
    end

    assign word = rom[addr];

    always_comb begin
        if (addr >= UA_W'(3) && addr[2:0] == 3'd1)
            AST_TEST_ONLY_QUIET: assert (word.ctrl == '0); // R9
    end
endmodule

// File: rtl/useq_optable.sv
module useq_optable
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  start
);
    logic [UA_W-1:0] tbl [OPS];

    for (genvar j = 0; j < OPS; j++) begin : g_tbl
        assign tbl[j] = op_start(OPC_W'(j));
    end

    assign start = tbl[opcode];
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  uword_t          word,
    input  logic [UA_W-1:0] upc,
    input  logic [UA_W-1:0] tbl_start,
    input  logic [UA_W-1:0] ext_addr,
    input  logic            flag_n,
    input  logic            flag_z,
    output logic [UA_W-1:0] nxt
);
    logic            take;
    logic [UA_W-1:0] step;

    assign step = UA_W'(upc + 1'b1);
    assign take = cond_hold(word.cond, flag_n, flag_z);

    always_comb begin
        nxt = step;
        if (take) begin
            case (word.src)
                S_TBL:   nxt = tbl_start;
                S_EXT:   nxt = ext_addr;
                S_TGT:   nxt = word.tgt;
                default: nxt = step;
            endcase
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [UA_W-1:0]   ext_addr,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [UA_W-1:0]   upc
);
    uword_t          word;
    logic [UA_W-1:0] tbl_start;
    logic [UA_W-1:0] nxt;

    useq_store u_store (
        .addr (upc),
        .word (word)
    );

    useq_optable u_tbl (
        .opcode (opcode),
        .start  (tbl_start)
    );

    useq_nextaddr u_next (
        .word      (word),
        .upc       (upc),
        .tbl_start (tbl_start),
        .ext_addr  (ext_addr),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc      <= '0;
            ctrl_out <= '0;
        end else begin
            upc      <= nxt;
            ctrl_out <= word.ctrl;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (upc == '0 && ctrl_out == '0)); // R1

    AST_NOBRANCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (word.cond == C_NONE) |=> (upc == UA_W'($past(upc) + 1'b1))); // R2

    AST_FAILED_TEST_STEP: assert property (@(posedge clk) disable iff (rst)
        (word.cond != C_NONE && !cond_hold(word.cond, flag_n, flag_z))
        |=> (upc == UA_W'($past(upc) + 1'b1))); // R5

    AST_EXT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (word.src == S_EXT && cond_hold(word.cond, flag_n, flag_z))
        |=> (upc == $past(ext_addr))); // R3

    AST_TABLE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (word.src == S_TBL && cond_hold(word.cond, flag_n, flag_z))
        |=> (upc == UA_W'({$past(opcode), 3'b000}))); // R7

    AST_FETCH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_W'(1)) |=> (ctrl_out == CTRL_W'(16'h8002))); // R8
endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  opcode;
    logic [7:0]  ext_addr;
    logic        flag_n;
    logic        flag_z;
    logic [15:0] ctrl_out;
    logic [7:0]  upc;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    int m_upc, m_ctrl;
    string tag_u, tag_c;

    always #2.5 clk = ~clk;

    useq_top u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .ext_addr(ext_addr),
        .flag_n(flag_n), .flag_z(flag_z), .ctrl_out(ctrl_out), .upc(upc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of the microprogram, written from R8 and R9
    task automatic ref_word(input int a, output int c, output int cnd,
                            output int s, output int t);
        int k;
        k = a % 8;
        c = ((a << 8) | 8'hA0 | k) & 16'hFFFF;
        cnd = 0; s = 0; t = 0;
        if (a < 3) begin
            c = 16'h8000 | (1 << a);
            if (a == 2) begin cnd = 1; s = 1; end
        end else begin
            case (k)
                1: begin c = 0; cnd = 2; s = 3; t = a + 5; end
                2: begin cnd = 3; s = 2; end
                3: begin cnd = 4; s = 3; t = 0; end
                4: begin cnd = 5; s = 1; end
                5: begin cnd = 1; s = 0; end
                6: begin cnd = 0; s = 3; t = 8'h55; end
                7: begin cnd = 1; s = 3; t = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic model_step();
        int c, cnd, s, t;
        bit hold;
        if (rst) begin
            m_upc = 0; m_ctrl = 0; tag_u = "R1"; tag_c = "R1";
            return;
        end
        ref_word(m_upc, c, cnd, s, t);
        tag_c = (m_upc < 3) ? "R8" : ((c == 0) ? "R9" : "R6");
        hold = (cnd == 1) || (cnd == 2 && flag_n) || (cnd == 3 && !flag_n)
            || (cnd == 4 && flag_z) || (cnd == 5 && !flag_z);
        m_ctrl = c;
        if (cnd == 0) begin
            tag_u = "R2"; m_upc = (m_upc + 1) % 256;
        end else if (!hold) begin
            tag_u = "R5"; m_upc = (m_upc + 1) % 256;
        end else begin
            case (s)
                0: begin tag_u = "R4"; m_upc = (m_upc + 1) % 256; end
                1: begin tag_u = "R7"; m_upc = opcode * 8; end
                2: begin tag_u = "R3"; m_upc = ext_addr; end
                default: begin tag_u = "R4"; m_upc = t; end
            endcase
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++; failed++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; opcode = '0; ext_addr = '0; flag_n = 1'b0; flag_z = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset upc", int'(upc), 0);
        chk("R1 reset ctrl", int'(ctrl_out), 0);
        m_upc = 0; m_ctrl = 0;
        rst = 1'b0;
        model_step();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk({tag_u, " next microaddress"}, int'(upc), m_upc);
            chk({tag_c, " control field"}, int'(ctrl_out), m_ctrl);
            opcode   = 5'($urandom);
            ext_addr = 8'($urandom);
            flag_n   = 1'($urandom);
            flag_z   = 1'($urandom);
            rst      = (i == 2000);
            model_step();
        end
        @(negedge clk);
        finish_run();
    end
endmodule